// File: doc/BRIEF.md
# Pixel Clock Divider with Source Doubling

This block turns a system clock into the pixel timing for a display panel. It does not produce a new clock net. Instead it produces a one-cycle enable strobe at the start of every pixel period. It also produces a pixel clock level that can be inverted and then driven to the panel pin. The period is an integer number of source ticks, taken from a configuration word.

The logic runs on a single clock, `clk`, which is the doubled-rate source. The base system rate is taken as every other cycle of `clk`. When the fast-source bit is set, every cycle of `clk` counts as a source tick. This gives finer ratios for fast panels, where half the base rate would fall short of the pixel rate.

The configuration word also carries the divide ratio and a polarity bit. A ratio below two is raised to two. A new ratio takes effect only at the next period boundary, so no pixel clock pulse is ever shortened. Dropping `run` parks the output at its inactive level and clears the counter. The next rise of `run` starts a fresh period at once.

Top module: `pclk_divider`

## Requirements
- R1: While `rst` is high, and on the first sampling after it, `pix_stb` is 0 and `pix_clk` is 0.
- R2: With the fast bit at 0, a source tick occurs every second `clk` cycle, so strobes are 2*N `clk` cycles apart. With the fast bit at 1, every cycle is a tick and strobes are N cycles apart. Here N is the effective ratio.
- R3: A ratio field of 0 or 1 behaves exactly as a ratio of 2.
- R4: `pix_stb` is high for exactly one `clk` cycle per period, and only when `run` was high on the previous edge.
- R5: With the polarity bit at 0, `pix_clk` is high in the strobe cycle and stays high for floor(N/2) source ticks. It is then low for the rest of the period.
- R6: With the polarity bit at 1, `pix_clk` is the complement of the R5 waveform. Strobe timing does not change.
- R7: A ratio written in the middle of a period does not change that period. The running period completes with its old length and high time, and the new ratio applies from the next strobe.
- R8: While `run` is low, from the next edge on, `pix_stb` is 0 and `pix_clk` equals the polarity bit. On the first edge with `run` high, a new period starts, so `pix_stb` is 1 in the following cycle.
- R9: The configuration word holds the fast-source select at bit 0 and the polarity at bit 1. It holds the ratio at bits [DIV_W+1:2], as an unsigned value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Doubled-rate source clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables the clock stage |
| cfg_word | input | DIV_W+2 | {ratio, polarity, fast select} |
| pix_stb | output | 1 | One-cycle strobe at each pixel period start |
| pix_clk | output | 1 | Pixel clock level after polarity |

## Verification
The assertions check these properties on every cycle:
- the single-cycle width of the strobe;
- that a strobe appears only while the stage is running;
- the parked level after `run` falls;
- that the pixel clock is at its active level in every strobe cycle;
- a minimum spacing of two cycles between strobes, which follows from the clamp.

Only the bench scenarios can show the following:
- the exact period length and high time, for each source mode, polarity and random ratio;
- the clamp of ratios 0 and 1;
- that a ratio change in mid-period is deferred to the next boundary.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  // configuration word field positions
  localparam int unsigned FAST_BIT  = 0;
  localparam int unsigned INV_BIT   = 1;
  localparam int unsigned RATIO_LSB = 2;

  typedef enum logic {
    SRC_BASE   = 1'b0,
    SRC_DOUBLE = 1'b1
  } src_mode_e;
endpackage

// File: rtl/pclk_src_gate.sv
// Produces source ticks: every cycle in double mode, every other cycle in base mode.
module pclk_src_gate (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  pclk_pkg::src_mode_e  mode,
  output logic                 tick
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst || !run) half_q <= 1'b0;
    else             half_q <= ~half_q;
  end

  // first running cycle is always a tick
  assign tick = run && ((mode == pclk_pkg::SRC_DOUBLE) || !half_q);
endmodule

// File: rtl/pclk_period_cnt.sv
// Counts source ticks within a period; latches the clamped ratio at each boundary.
module pclk_period_cnt #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] ratio_req,
  output logic             period_start,
  output logic             hi_phase
);
  localparam logic [DIV_W-1:0] MIN_N = DIV_W'(2);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cur_n_q;
  logic [DIV_W-1:0] ratio_eff;
  logic [DIV_W-1:0] n_use;
  logic             at_zero;
  logic             last;

  assign ratio_eff    = (ratio_req < MIN_N) ? MIN_N : ratio_req;
  assign at_zero      = (cnt_q == '0);
  assign n_use        = at_zero ? ratio_eff : cur_n_q;
  assign last         = (cnt_q == n_use - 1'b1);
  assign period_start = tick && at_zero;
  assign hi_phase     = (cnt_q < (n_use >> 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      cur_n_q <= MIN_N;
    end else if (tick) begin
      cnt_q   <= last ? '0 : cnt_q + 1'b1;
      cur_n_q <= n_use;
    end
  end
endmodule

// File: rtl/pclk_out_stage.sv
// Registers the strobe and the polarity-adjusted pixel clock level.
module pclk_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic period_start,
  input  logic hi_phase,
  input  logic invert,
  output logic pix_stb,
  output logic pix_clk
);
  logic raw_q;
  logic raw_next;
  logic stb_q;
  logic pclk_q;

  assign raw_next = run && (tick ? hi_phase : raw_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= 1'b0;
      stb_q  <= 1'b0;
      pclk_q <= 1'b0;
    end else begin
      raw_q  <= raw_next;
      stb_q  <= run && period_start;
      pclk_q <= raw_next ^ invert;
    end
  end

  assign pix_stb = stb_q;
  assign pix_clk = pclk_q;
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
  parameter int DIV_W = 8,
  localparam int CFG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             pix_stb,
  output logic             pix_clk
);
  import pclk_pkg::*;

  src_mode_e        mode;
  logic             invert;
  logic [DIV_W-1:0] ratio;
  logic             tick;
  logic             period_start;
  logic             hi_phase;

  assign mode   = src_mode_e'(cfg_word[FAST_BIT]);
  assign invert = cfg_word[INV_BIT];
  assign ratio  = cfg_word[RATIO_LSB +: DIV_W];

  pclk_src_gate u_src (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .mode (mode),
    .tick (tick)
  );

  pclk_period_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .tick         (tick),
    .ratio_req    (ratio),
    .period_start (period_start),
    .hi_phase     (hi_phase)
  );

  pclk_out_stage u_out (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .tick         (tick),
    .period_start (period_start),
    .hi_phase     (hi_phase),
    .invert       (invert),
    .pix_stb      (pix_stb),
    .pix_clk      (pix_clk)
  );
endmodule

// File: rtl/pclk_divider_chk.sv
module pclk_divider_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic pol,
  input logic pix_stb,
  input logic pix_clk
);
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (pix_stb) begin
      gap_q  <= 16'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_stb_single_R4: assert property (@(posedge clk) disable iff (rst)
    pix_stb |=> !pix_stb);

  assert_stb_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
    pix_stb |-> $past(run));

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!pix_stb && (pix_clk == $past(pol))));

  assert_active_at_stb_R5: assert property (@(posedge clk) disable iff (rst)
    pix_stb |-> (pix_clk != $past(pol)));

  assert_min_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (seen_q && pix_stb) |-> (gap_q >= 16'd2));
endmodule

bind pclk_divider pclk_divider_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (run),
  .pol     (cfg_word[pclk_pkg::INV_BIT]),
  .pix_stb (pix_stb),
  .pix_clk (pix_clk)
);

// File: tb/sim_pclk_divider.sv
module sim_pclk_divider;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;
  localparam int CFG_W = DIV_W + 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             run = 1'b0;
  logic [CFG_W-1:0] cfg_word = '0;
  logic             pix_stb;
  logic             pix_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_divider #(.DIV_W(DIV_W)) u0 (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .cfg_word (cfg_word),
    .pix_stb  (pix_stb),
    .pix_clk  (pix_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_ratio(input int r);
    return (r < 2) ? 2 : r;
  endfunction

  function automatic logic [CFG_W-1:0] pack(input bit fast, input bit inv, input int r);
    return {DIV_W'(r), inv, fast};  // R9 field layout
  endfunction

  // stop, check parked level, then restart and check the first strobe
  task automatic start(input bit fast, input bit inv, input int r);
    run = 1'b0;
    cfg_word = pack(fast, inv, r);
    repeat (3) @(negedge clk);
    check(pix_clk == inv && !pix_stb, "R8 parked", int'(pix_clk), int'(inv));
    run = 1'b1;
    @(negedge clk);
    check(pix_stb == 1'b1, "R8 restart", int'(pix_stb), 1);
    check(pix_clk == !inv, "R5 active at strobe", int'(pix_clk), int'(!inv));
  endtask

  // called at a negedge where pix_stb is high; measures reps periods
  task automatic measure(input int n_eff, input bit fast, input bit inv, input int reps);
    int s;
    s = fast ? 1 : 2;
    for (int k = 0; k < reps; k++) begin
      int per;
      int hi;
      per = 0;
      hi = 0;
      do begin
        if (pix_clk != inv) hi++;
        per++;
        @(negedge clk);
      end while (!pix_stb && per < 4000);
      check(per == n_eff * s, "R2 R9 period", per, n_eff * s);
      check(hi == (n_eff / 2) * s, inv ? "R6 high time" : "R5 high time", hi, (n_eff / 2) * s);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED1234);
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!pix_stb, "R1 stb in reset", int'(pix_stb), 0);
    check(!pix_clk, "R1 clk in reset", int'(pix_clk), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!pix_stb && !pix_clk, "R1 after reset", int'(pix_clk), 0);

    // directed: clamp cases R3
    start(1'b0, 1'b0, 0); measure(2, 1'b0, 1'b0, 2);
    start(1'b1, 1'b0, 1); measure(2, 1'b1, 1'b0, 2);
    start(1'b1, 1'b1, 2); measure(2, 1'b1, 1'b1, 2);
    // odd ratio, both modes
    start(1'b0, 1'b1, 5); measure(5, 1'b0, 1'b1, 2);
    start(1'b1, 1'b0, 7); measure(7, 1'b1, 1'b0, 2);
    // largest ratio
    start(1'b1, 1'b0, 255); measure(255, 1'b1, 1'b0, 1);

    // R7: change ratio mid-period, fast mode, 6 -> 3
    start(1'b1, 1'b0, 6);
    begin
      int per;
      int hi;
      per = 0;
      hi = 0;
      for (int k = 0; k < 2; k++) begin
        if (pix_clk) hi++;
        per++;
        @(negedge clk);
      end
      cfg_word = pack(1'b1, 1'b0, 3);
      do begin
        if (pix_clk) hi++;
        per++;
        @(negedge clk);
      end while (!pix_stb && per < 4000);
      check(per == 6, "R7 old period kept", per, 6);
      check(hi == 3, "R7 no shortened pulse", hi, 3);
      measure(3, 1'b1, 1'b0, 2);
    end

    // R6: polarity flip while running leaves strobe timing intact
    start(1'b1, 1'b0, 8);
    repeat (2) @(negedge clk);
    cfg_word = pack(1'b1, 1'b1, 8);
    @(negedge clk);
    check(pix_clk == 1'b0, "R6 flipped level", int'(pix_clk), 0);
    begin
      int per;
      per = 3;
      while (!pix_stb && per < 4000) begin
        per++;
        @(negedge clk);
      end
      check(per == 8, "R6 strobe timing", per, 8);
    end
    measure(8, 1'b1, 1'b1, 1);

    // random configurations
    for (int i = 0; i < 12; i++) begin
      bit fast;
      bit inv;
      int r;
      fast = 1'($urandom);
      inv  = 1'($urandom);
      r    = int'($urandom_range(0, 20));
      start(fast, inv, r);
      measure(eff_ratio(r), fast, inv, 2);
    end

    // R8: stop mid-period
    run = 1'b0;
    @(negedge clk);
    check(!pix_stb && pix_clk == cfg_word[1], "R8 stop mid-period", int'(pix_clk), int'(cfg_word[1]));

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule